// File: doc/BRIEF.md
# Digital Input Glitch Filter

This block cleans up a bank of slow digital inputs before they reach port read-back and change-detection logic. The bank holds up to twelve ports of eight channels each. Each channel can be routed through a hold-time filter or straight past it. Every raw input first crosses into the clock domain through a two-stage synchroniser.

A filtered channel changes its output only after its synchronised input has disagreed with that output for a programmed number of 200 ns ticks. A prescaler derives the ticks from the system clock, whose frequency is a parameter. One 20-bit interval is shared by all channels. Each channel has its own enable bit, held in one mask byte per port. Configuration is written over a byte-wide bus: one write strobe, an 8-bit address and an 8-bit data value.

Top module: `din_glitch_filter`

## Requirements
- R1: After reset every output is 0, every enable bit is 0 (all channels bypass the filter) and the interval is 0.
- R2: A channel whose enable bit is 0 shows a change of its raw input at its output on the third rising clock edge after the change: two synchroniser edges, then the output register.
- R3: The enable mask of port p is written at address 0x44 + 0x10·p. Data bit b enables channel 8·p + b. A write to one port's mask leaves the other channels unchanged.
- R4: With interval N > 0, an enabled channel ignores a pulse lasting fewer than (N−1)·T clock cycles, where T is the number of clock cycles in 200 ns (25 at 125 MHz).
- R5: With interval N > 0, an enabled channel does not follow a new level within (N−1)·T cycles, and does follow it once the level has been held for (N+1)·T + 3 cycles.
- R6: With interval 0, an enabled channel has the same latency as a bypassed channel, so a one-cycle pulse passes through.
- R7: The interval is written as three bytes. Bits 7:0 go to 0x08 and bits 15:8 go to 0x09, and both are only staged. A write to 0x0A supplies bits 19:16 in data bits 3:0 and loads all 20 bits at once. Staging writes alone do not change filtering.
- R8: A write to 0x0A with any of data bits 7:4 set loads the maximum interval 0xFFFFF.
- R9: The hold count restarts whenever the synchronised input matches the output again, so two short pulses separated by a gap do not add up.
- R10: A newly loaded interval applies from the clock edge after the loading write. A channel that is already counting, and whose count meets the new value, switches on that edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| raw_in | input | 8·NUM_PORTS | Asynchronous raw inputs, channel 8·p+b at bit 8·p+b |
| filt_out | output | 8·NUM_PORTS | Filtered or bypassed channel outputs |

## Verification
Two things can land on the same edge: an interval load from the bus, and the count comparison of a channel that is in the middle of a hold. The bench provokes this by stepping an enabled channel while the interval is very long. It then commits interval 0 over the bus while that channel is still counting. The output must still be at its old level just after the commit edge and must take the new level exactly one edge later. This shows the comparison used the old interval on the commit edge and the new one after it, with no intermediate value.

// File: rtl/dgf_pkg.sv
`timescale 1ns/1ps
package dgf_pkg;
    localparam int BYTE_W   = 8;
    localparam int IVL_W    = 20;
    localparam int MAX_PORTS = 12;
    localparam logic [IVL_W-1:0] IVL_MAX = '1;

    localparam logic [7:0] A_IVL_B0    = 8'h08;
    localparam logic [7:0] A_IVL_B1    = 8'h09;
    localparam logic [7:0] A_IVL_B2    = 8'h0A;
    localparam logic [7:0] A_MASK_BASE = 8'h44;
    localparam logic [7:0] A_MASK_STEP = 8'h10;

    function automatic logic [7:0] mask_addr(input int p);
        return 8'(int'(A_MASK_BASE) + p * int'(A_MASK_STEP));
    endfunction
endpackage

// File: rtl/dgf_tick_gen.sv
`timescale 1ns/1ps
module dgf_tick_gen #(
    parameter int CLK_HZ  = 125_000_000,
    parameter int TICK_NS = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam longint CYC_L    = (longint'(CLK_HZ) * longint'(TICK_NS)) / 64'd1_000_000_000;
    localparam int     TICK_CYC = (CYC_L < 1) ? 1 : int'(CYC_L);
    localparam int     CNT_W    = (TICK_CYC < 2) ? 1 : $clog2(TICK_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } tg_state_t;

    tg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/dgf_cfg_regs.sv
`timescale 1ns/1ps
module dgf_cfg_regs
    import dgf_pkg::*;
#(
    parameter int NUM_PORTS = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [7:0]                    cfg_addr,
    input  logic [7:0]                    cfg_wdata,
    output logic [IVL_W-1:0]              ivl,
    output logic [NUM_PORTS*BYTE_W-1:0]   en
);
    localparam int NCH = NUM_PORTS * BYTE_W;

    typedef struct packed {
        logic [7:0]       stg_b0;
        logic [7:0]       stg_b1;
        logic [IVL_W-1:0] ivl;
        logic [NCH-1:0]   en;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (cfg_addr == A_IVL_B0) st_d.stg_b0 = cfg_wdata;
            if (cfg_addr == A_IVL_B1) st_d.stg_b1 = cfg_wdata;
            if (cfg_addr == A_IVL_B2) begin
                if (cfg_wdata[7:4] != 4'h0) st_d.ivl = IVL_MAX;
                else                        st_d.ivl = {cfg_wdata[3:0], st_q.stg_b1, st_q.stg_b0};
            end
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (cfg_addr == mask_addr(p)) st_d.en[p*BYTE_W +: BYTE_W] = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ivl = st_q.ivl;
    assign en  = st_q.en;
endmodule

// File: rtl/dgf_chan.sv
`timescale 1ns/1ps
module dgf_chan
    import dgf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic [IVL_W-1:0] ivl,
    input  logic             raw_s,
    output logic             filt
);
    typedef struct packed {
        logic [IVL_W-1:0] cnt;
        logic             filt;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.filt = raw_s;
            st_d.cnt  = '0;
        end else if (raw_s == st_q.filt) begin
            st_d.cnt  = '0;
        end else if (st_q.cnt >= ivl) begin
            st_d.filt = raw_s;
            st_d.cnt  = '0;
        end else if (tick) begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt = st_q.filt;
endmodule

// File: rtl/din_glitch_filter.sv
`timescale 1ns/1ps
module din_glitch_filter
    import dgf_pkg::*;
#(
    parameter int NUM_PORTS = 12,
    parameter int CLK_HZ    = 125_000_000,
    parameter int TICK_NS   = 200
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [7:0]                  cfg_addr,
    input  logic [7:0]                  cfg_wdata,
    input  logic [NUM_PORTS*8-1:0]      raw_in,
    output logic [NUM_PORTS*8-1:0]      filt_out
);
    localparam int NCH = NUM_PORTS * BYTE_W;

    typedef struct packed {
        logic [NCH-1:0] s1;
        logic [NCH-1:0] s2;
    } sync_state_t;

    sync_state_t      sync_d, sync_q;
    logic [NCH-1:0]   raw_s;
    logic [NCH-1:0]   en_w;
    logic [IVL_W-1:0] ivl_w;
    logic             tick_w;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = raw_in;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign raw_s = sync_q.s2;

    dgf_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_NS(TICK_NS)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_w)
    );

    dgf_cfg_regs #(.NUM_PORTS(NUM_PORTS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .ivl      (ivl_w),
        .en       (en_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dgf_chan u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick_w),
            .en   (en_w[c]),
            .ivl  (ivl_w),
            .raw_s(raw_s[c]),
            .filt (filt_out[c])
        );
    end
endmodule

// File: rtl/din_glitch_filter_chk.sv
`timescale 1ns/1ps
module din_glitch_filter_chk
    import dgf_pkg::*;
#(
    parameter int NUM_PORTS = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_we,
    input logic [7:0]                 cfg_addr,
    input logic [IVL_W-1:0]           ivl,
    input logic [NUM_PORTS*8-1:0]     en,
    input logic [NUM_PORTS*8-1:0]     raw_s,
    input logic [NUM_PORTS*8-1:0]     filt
);
    localparam int NCH = NUM_PORTS * 8;

    // R7: the interval only moves on the edge after a commit write
    a_r7_ivl_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_addr == A_IVL_B2) |=> $stable(ivl));

    // R3: enable masks only move on a bus write
    a_r3_mask_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(en));

    for (genvar c = 0; c < NCH; c++) begin : g_c
        // R2: bypassed channel copies the synchronised input
        a_r2_bypass_follows: assert property (@(posedge clk) disable iff (!rst_n)
            !en[c] |=> (filt[c] == $past(raw_s[c])));
        // R6: zero interval behaves like bypass
        a_r6_zero_ivl_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (en[c] && ivl == '0) |=> (filt[c] == $past(raw_s[c])));
        // R4: an output only ever moves toward the synchronised input
        a_r4_moves_toward_input: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(filt[c]) |-> (filt[c] == $past(raw_s[c])));
    end
endmodule

bind din_glitch_filter din_glitch_filter_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_addr(cfg_addr),
    .ivl     (ivl_w),
    .en      (en_w),
    .raw_s   (raw_s),
    .filt    (filt_out)
);

// File: tb/din_glitch_filter_tb.sv
`timescale 1ns/1ps
module din_glitch_filter_tb;
    localparam int NP  = 12;
    localparam int NCH = NP * 8;
    localparam int T   = 25;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [7:0]     cfg_addr = '0;
    logic [7:0]     cfg_wdata = '0;
    logic [NCH-1:0] raw_in = '0;
    logic [NCH-1:0] filt_out;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    din_glitch_filter #(.NUM_PORTS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .raw_in(raw_in), .filt_out(filt_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_raw(input int ch, input logic v);
        @(posedge clk); #1;
        raw_in[ch] = v;
    endtask

    task automatic watch(input int ch, input int n, input logic exp, input string req);
        int bad = 0;
        repeat (n) begin
            @(negedge clk);
            if (filt_out[ch] !== exp) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(filt_out == '0, "R1 outputs zero after reset", filt_out[31:0], 0);
        set_raw(40, 1'b1);
        repeat (4) @(negedge clk);
        check(filt_out[40] == 1'b1, "R1 channels bypass after reset", filt_out[40], 1);
        set_raw(40, 1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_bypass_latency();
        set_raw(8, 1'b1);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(filt_out[8] == 1'b0, "R2 not before third edge", filt_out[8], 0);
        @(posedge clk); @(negedge clk);
        check(filt_out[8] == 1'b1, "R2 output on third edge", filt_out[8], 1);
        set_raw(8, 1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_zero_interval();
        wr(8'h74, 8'h20);                 // enable channel 29
        set_raw(29, 1'b1);
        set_raw(29, 1'b0);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(filt_out[29] == 1'b1, "R6 one-cycle pulse passes", filt_out[29], 1);
        @(negedge clk);
        check(filt_out[29] == 1'b0, "R6 pulse ends next cycle", filt_out[29], 0);
    endtask

    task automatic t_hold_filter();
        wr(8'h08, 8'h02);
        wr(8'h0A, 8'h00);                 // interval 2 ticks
        set_raw(29, 1'b1);
        repeat (19) set_raw(29, 1'b1);
        set_raw(29, 1'b0);
        watch(29, 40, 1'b0, "R4 short pulse suppressed");
        // R9: two short pulses with a gap
        set_raw(29, 1'b1);
        repeat (19) set_raw(29, 1'b1);
        set_raw(29, 1'b0);
        repeat (2) set_raw(29, 1'b0);
        set_raw(29, 1'b1);
        repeat (19) set_raw(29, 1'b1);
        set_raw(29, 1'b0);
        watch(29, 40, 1'b0, "R9 count restarts after gap");
        // R5: long hold
        set_raw(29, 1'b1);
        watch(29, T - 6, 1'b0, "R5 no early change");
        repeat (2 * T + 30) @(negedge clk);
        check(filt_out[29] == 1'b1, "R5 level passes after hold", filt_out[29], 1);
        set_raw(29, 1'b0);
        repeat (3 * T + 10) @(negedge clk);
        check(filt_out[29] == 1'b0, "R5 falling level passes", filt_out[29], 0);
    endtask

    task automatic t_mask_and_commit();
        wr(8'h08, 8'h00);
        wr(8'h09, 8'h00);
        wr(8'h0A, 8'h01);                 // interval 0x10000 ticks
        wr(8'h44, 8'h01);                 // channel 0
        wr(8'hF4, 8'h80);                 // channel 95
        set_raw(0, 1'b1);
        raw_in[8] = 1'b1; raw_in[95] = 1'b1; raw_in[94] = 1'b1;
        repeat (10) @(negedge clk);
        check(filt_out[8]  == 1'b1, "R3 port1 bit0 still bypassed", filt_out[8], 1);
        check(filt_out[94] == 1'b1, "R3 port11 bit6 still bypassed", filt_out[94], 1);
        check(filt_out[0]  == 1'b0, "R3 port0 bit0 filtered", filt_out[0], 0);
        check(filt_out[95] == 1'b0, "R3 port11 bit7 filtered", filt_out[95], 0);
        // R7: staging writes alone change nothing
        wr(8'h08, 8'h00);
        wr(8'h09, 8'h00);
        repeat (10) @(negedge clk);
        check(filt_out[0] == 1'b0, "R7 staged bytes not applied", filt_out[0], 0);
        // R10: commit while channel 0 is counting
        wr(8'h0A, 8'h00);
        @(negedge clk);
        check(filt_out[0] == 1'b0, "R10 old interval on commit edge", filt_out[0], 0);
        @(posedge clk); @(negedge clk);
        check(filt_out[0] == 1'b1, "R10 new interval one edge later", filt_out[0], 1);
        raw_in[8] = 1'b0; raw_in[94] = 1'b0;
        set_raw(0, 1'b0);
        repeat (5) @(negedge clk);
        check(filt_out[95] == 1'b1, "R7 committed zero interval", filt_out[95], 1);
        set_raw(95, 1'b0);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_saturate();
        wr(8'h08, 8'h00);
        wr(8'h09, 8'h00);
        wr(8'h0A, 8'h10);                 // out of range high byte
        set_raw(0, 1'b1);
        watch(0, 500, 1'b0, "R8 saturated interval holds");
        set_raw(0, 1'b0);
        wr(8'h0A, 8'h00);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_bypass_latency();
        t_zero_interval();
        t_hold_filter();
        t_mask_and_commit();
        t_saturate();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule